// File: doc/BRIEF.md
# CPU Debug Register Access Port

A bus slave that gives an external debugger control over a small CPU. The debugger sees two bus words. The command word requests a halt, pulses a CPU reset or a single step, chooses which CPU register the data word refers to, and shows live status flags. The data word reads or writes the chosen register in the CPU register file.

Reads of the data word are served at any time, including while the CPU runs, so a debugger can sample the program counters on the fly. Reaching a register always takes two bus operations: one command write to select it, then one data access. Reading both program counters therefore costs four single operations.

Writes are accepted only while the CPU is halted. They are not applied to the register file directly. They are inserted into the CPU's own ALU writeback path one clock after the bus accepts them. When the CPU first reports itself halted, the port raises a one-cycle interrupt so the surrounding system can notice.

Top module: `dbg_port`

## Requirements
- R1: Address 0 is the command word and address 1 is the data word. `o_ack` is high exactly in the cycle after a strobe that is not stalled, and in no other cycle. Read data is valid while `o_ack` is high.
- R2: A command write loads the register select from bits 5:0 and the halt request from bit 8. A command read returns the select in bits 5:0, the halt request in bit 8, the CPU halted flag in bit 9, break-enable in bit 12, global interrupt enable in bit 13 and sleep in bit 14. All other bits read 0.
- R3: `o_halt_req` follows command bit 8. The halted bit (bit 9) reflects only the CPU's acknowledge `i_halted`, so it reads 0 until the CPU has actually stopped.
- R4: Writing 1 to command bit 10 gives a one-cycle `o_cpu_reset` pulse in the acknowledge cycle. Writing 1 to bit 11 gives a one-cycle `o_step` pulse in the same way. Both bits read as 0.
- R5: Selects 0 to 15 address the supervisor bank and selects 16 to 31 the user bank. The register-file address is select bits 4:0, so the two program counters are selects 15 and 31. Selects 32 to 63 read as 0, and data writes to them are dropped.
- R6: A data read returns the selected register as it was at the accepting edge, whether the CPU is halted or running. While the CPU runs, a data access is never stalled.
- R7: A data write accepted while the CPU is halted drives `o_rf_we`, `o_rf_waddr` and `o_rf_wdata` in the acknowledge cycle, taking priority over the ALU. The register holds the new value from the next cycle on.
- R8: A data write while the CPU is not halted is acknowledged and causes no register-file write.
- R9: A data-word access presented in the cycle a debug write occupies the writeback path is stalled for that one cycle. It then returns the newly written value.
- R10: `o_halt_irq` pulses high for exactly one cycle after `i_halted` rises.
- R11: The status flags in the command word can be read while the CPU is running.
- R12: When no debug write is pending, the writeback outputs pass the ALU writeback inputs through unchanged.
- R13: After reset, `o_ack`, `o_halt_req`, `o_cpu_reset`, `o_step`, `o_halt_irq` and `o_rf_we` (with the ALU idle) are 0, and the select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_reset | input | 1 | Synchronous active-high reset |
| i_stb | input | 1 | Bus strobe |
| i_we | input | 1 | Bus write enable |
| i_addr | input | 1 | 0 selects the command word, 1 selects the data word |
| i_wdata | input | DW | Bus write data |
| o_stall | output | 1 | Bus stall |
| o_ack | output | 1 | Bus acknowledge |
| o_rdata | output | DW | Bus read data |
| o_halt_req | output | 1 | Halt request to the CPU |
| i_halted | input | 1 | CPU acknowledges that it is halted |
| o_cpu_reset | output | 1 | One-cycle CPU reset pulse |
| o_step | output | 1 | One-cycle single-step pulse |
| o_halt_irq | output | 1 | Pulses when the CPU becomes halted |
| i_brk_en | input | 1 | CPU break-enable flag |
| i_gie | input | 1 | CPU global interrupt enable flag |
| i_sleep | input | 1 | CPU sleep flag |
| o_rf_raddr | output | 5 | Register-file read address |
| i_rf_rdata | input | DW | Register-file read data |
| i_alu_we | input | 1 | ALU writeback enable |
| i_alu_waddr | input | 5 | ALU writeback register |
| i_alu_wdata | input | DW | ALU writeback data |
| o_rf_we | output | 1 | Register-file write enable |
| o_rf_waddr | output | 5 | Register-file write register |
| o_rf_wdata | output | DW | Register-file write data |

## Verification
The assertions assume a bus master that keeps its strobe and request steady while stalled. They assume the CPU stops issuing ALU writebacks once it reports halted, because a debug write would otherwise hide an ALU write in the same cycle. They also assume `i_halted` changes only in response to the halt request. The bench meets these assumptions as follows: its CPU stub acknowledges a halt three cycles after the request, ALU writebacks are driven only while the stub runs, and every bus access waits out a stall before the strobe is dropped.

// File: rtl/dbg_port.sv
module dbg_port #(
  parameter int DW = 32
) (
  input  logic          i_clk,
  input  logic          i_reset,
  input  logic          i_stb,
  input  logic          i_we,
  input  logic          i_addr,
  input  logic [DW-1:0] i_wdata,
  output logic          o_stall,
  output logic          o_ack,
  output logic [DW-1:0] o_rdata,
  output logic          o_halt_req,
  input  logic          i_halted,
  output logic          o_cpu_reset,
  output logic          o_step,
  output logic          o_halt_irq,
  input  logic          i_brk_en,
  input  logic          i_gie,
  input  logic          i_sleep,
  output logic [4:0]    o_rf_raddr,
  input  logic [DW-1:0] i_rf_rdata,
  input  logic          i_alu_we,
  input  logic [4:0]    i_alu_waddr,
  input  logic [DW-1:0] i_alu_wdata,
  output logic          o_rf_we,
  output logic [4:0]    o_rf_waddr,
  output logic [DW-1:0] o_rf_wdata
);
  localparam int SELW   = 6;
  localparam int AW     = SELW - 1;
  localparam int HALT_B = 8;
  localparam int HLTD_B = 9;
  localparam int RST_B  = 10;
  localparam int STEP_B = 11;
  localparam int BRK_B  = 12;
  localparam int GIE_B  = 13;
  localparam int SLP_B  = 14;

  logic [SELW-1:0] sel;
  logic            halt_q, halted_q, wr_pend;
  logic [AW-1:0]   wr_reg;
  logic [DW-1:0]   wr_val, status;
  logic            take;

  assign o_stall    = i_stb & i_addr & wr_pend;
  assign take       = i_stb & ~o_stall;
  assign o_halt_req = halt_q;
  assign o_rf_raddr = sel[AW-1:0];

  assign o_rf_we    = wr_pend | i_alu_we;
  assign o_rf_waddr = wr_pend ? wr_reg : i_alu_waddr;
  assign o_rf_wdata = wr_pend ? wr_val : i_alu_wdata;

  always_comb begin
    status         = '0;
    status[SELW-1:0] = sel;
    status[HALT_B] = halt_q;
    status[HLTD_B] = i_halted;
    status[BRK_B]  = i_brk_en;
    status[GIE_B]  = i_gie;
    status[SLP_B]  = i_sleep;
  end

  always_ff @(posedge i_clk) begin
    if (i_reset) begin
      sel         <= '0;
      halt_q      <= 1'b0;
      halted_q    <= 1'b0;
      wr_pend     <= 1'b0;
      wr_reg      <= '0;
      wr_val      <= '0;
      o_ack       <= 1'b0;
      o_rdata     <= '0;
      o_cpu_reset <= 1'b0;
      o_step      <= 1'b0;
      o_halt_irq  <= 1'b0;
    end else begin
      o_ack       <= take;
      o_cpu_reset <= 1'b0;
      o_step      <= 1'b0;
      wr_pend     <= 1'b0;
      halted_q    <= i_halted;
      o_halt_irq  <= i_halted & ~halted_q;
      if (take) begin
        if (!i_addr) begin
          o_rdata <= status;
          if (i_we) begin
            sel         <= i_wdata[SELW-1:0];
            halt_q      <= i_wdata[HALT_B];
            o_cpu_reset <= i_wdata[RST_B];
            o_step      <= i_wdata[STEP_B];
          end
        end else begin
          o_rdata <= sel[SELW-1] ? '0 : i_rf_rdata;
          if (i_we && i_halted && !sel[SELW-1]) begin
            wr_pend <= 1'b1;
            wr_reg  <= sel[AW-1:0];
            wr_val  <= i_wdata;
          end
        end
      end
    end
  end

  // R1
  ack_after_stb_chk: assert property (@(posedge i_clk) disable iff (i_reset)
    (i_stb && !o_stall) |=> o_ack);

  // R1
  no_spurious_ack_chk: assert property (@(posedge i_clk) disable iff (i_reset)
    !(i_stb && !o_stall) |=> !o_ack);

  // R7
  dbg_wb_latency_chk: assert property (@(posedge i_clk) disable iff (i_reset)
    (i_stb && !o_stall && i_we && i_addr && i_halted && !sel[SELW-1]) |=>
      (o_rf_we && o_rf_waddr == $past(o_rf_raddr) && o_rf_wdata == $past(i_wdata)));

  // R8
  run_write_drop_chk: assert property (@(posedge i_clk) disable iff (i_reset)
    (i_stb && !o_stall && i_we && i_addr && !i_halted) |=>
      (o_rf_we == i_alu_we && o_rf_waddr == i_alu_waddr));

  // R6
  run_no_stall_chk: assert property (@(posedge i_clk) disable iff (i_reset)
    (!i_halted && !$past(i_halted)) |-> !o_stall);

  // R10
  halt_irq_pulse_chk: assert property (@(posedge i_clk) disable iff (i_reset)
    o_halt_irq |=> !o_halt_irq);

  // R10
  halt_irq_cause_chk: assert property (@(posedge i_clk) disable iff (i_reset)
    $rose(o_halt_irq) |-> $past(i_halted));

  // R4
  reset_pulse_chk: assert property (@(posedge i_clk) disable iff (i_reset)
    o_cpu_reset |=> !o_cpu_reset);
endmodule

// File: tb/tb_dbg_port.sv
module tb_dbg_port;
  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic        stb = 0, we = 0, adr = 0;
  logic [31:0] wd = '0;
  logic        stall, ack, halt_req, cpu_rst, step, irq;
  logic [31:0] rdata, rf_rdata, rf_wdata;
  logic [4:0]  rf_raddr, rf_waddr;
  logic        rf_we;
  logic        alu_we = 0;
  logic [4:0]  alu_waddr = '0;
  logic [31:0] alu_wdata = '0;
  logic [2:0]  hs;
  logic        halted;
  logic [31:0] rf [32];

  dbg_port #(.DW(32)) dut (
    .i_clk(clk), .i_reset(rst), .i_stb(stb), .i_we(we), .i_addr(adr), .i_wdata(wd),
    .o_stall(stall), .o_ack(ack), .o_rdata(rdata), .o_halt_req(halt_req),
    .i_halted(halted), .o_cpu_reset(cpu_rst), .o_step(step), .o_halt_irq(irq),
    .i_brk_en(1'b1), .i_gie(1'b0), .i_sleep(1'b1),
    .o_rf_raddr(rf_raddr), .i_rf_rdata(rf_rdata),
    .i_alu_we(alu_we), .i_alu_waddr(alu_waddr), .i_alu_wdata(alu_wdata),
    .o_rf_we(rf_we), .o_rf_waddr(rf_waddr), .o_rf_wdata(rf_wdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      hs <= '0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'hA000_0000 + i;
    end else begin
      hs <= {hs[1:0], halt_req};
      if (rf_we) rf[rf_waddr] <= rf_wdata;
    end
  end
  assign halted   = hs[2];
  assign rf_rdata = rf[rf_raddr];

  int irq_cnt = 0;
  always @(posedge clk) if (!rst && irq) irq_cnt++;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] rd_last;
  int stalls_last;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic a, input logic [31:0] d);
    @(negedge clk);
    stb = 1; we = w; adr = a; wd = d;
    stalls_last = 0;
    #1;
    while (stall) begin
      stalls_last++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    stb = 0; we = 0;
    rd_last = rdata;
    chk(ack === 1'b1, "R1 ack", {31'b0, ack}, 32'h1);
  endtask

  localparam int NV = 13;
  // {we, addr, wdata, expected, check}
  localparam logic [66:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'h0000_0103, 32'h0, 1'b0},
    {1'b1, 1'b1, 32'hDEAD_0003, 32'h0, 1'b0},
    {1'b0, 1'b1, 32'h0, 32'hDEAD_0003, 1'b1},
    {1'b0, 1'b0, 32'h0, 32'h0000_5303, 1'b1},
    {1'b1, 1'b0, 32'h0000_010F, 32'h0, 1'b0},
    {1'b1, 1'b1, 32'h0000_1000, 32'h0, 1'b0},
    {1'b1, 1'b0, 32'h0000_011F, 32'h0, 1'b0},
    {1'b1, 1'b1, 32'h0000_2000, 32'h0, 1'b0},
    {1'b0, 1'b1, 32'h0, 32'h0000_2000, 1'b1},
    {1'b1, 1'b0, 32'h0000_010F, 32'h0, 1'b0},
    {1'b0, 1'b1, 32'h0, 32'h0000_1000, 1'b1},
    {1'b1, 1'b0, 32'h0000_0100, 32'h0, 1'b0},
    {1'b0, 1'b1, 32'h0, 32'hA000_0000, 1'b1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    chk(ack === 0 && halt_req === 0 && irq === 0 && cpu_rst === 0 && step === 0 && rf_we === 0,
        "R13 reset outputs", {ack, halt_req, irq, cpu_rst, step, rf_we}, 32'h0);
    rst = 0;

    // R11 R2: status readable while running
    bus(0, 0, 0);
    chk(rd_last === 32'h0000_5000, "R11 status while running", rd_last, 32'h5000);
    // R6: data read while running, no stall
    bus(0, 1, 0);
    chk(rd_last === 32'hA000_0000 && stalls_last == 0, "R6 run read", rd_last, 32'hA000_0000);
    // R8: running write ignored
    bus(1, 1, 32'h0000_0077);
    chk(rf_we === 1'b0, "R8 no rf write", {31'b0, rf_we}, 32'h0);
    bus(0, 1, 0);
    chk(rd_last === 32'hA000_0000, "R8 value kept", rd_last, 32'hA000_0000);

    // R12: ALU pass-through
    @(negedge clk);
    alu_we = 1; alu_waddr = 5'd5; alu_wdata = 32'h55;
    #1;
    chk(rf_we === 1 && rf_waddr === 5'd5 && rf_wdata === 32'h55, "R12 alu passthrough", rf_wdata, 32'h55);
    @(negedge clk);
    alu_we = 0;

    // R3 R10: halt handshake
    bus(1, 0, 32'h0000_0100);
    chk(halt_req === 1'b1, "R3 halt request", {31'b0, halt_req}, 32'h1);
    bus(0, 0, 0);
    chk(rd_last === 32'h0000_5100, "R3 halted not yet", rd_last, 32'h5100);
    repeat (5) @(negedge clk);
    bus(0, 0, 0);
    chk(rd_last === 32'h0000_5300, "R3 halted ack", rd_last, 32'h5300);
    chk(irq_cnt == 1, "R10 one irq pulse", irq_cnt, 1);

    // R1 R2 R5 R6 R7: vector table
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][66], VEC[i][65], VEC[i][64:33]);
      if (VEC[i][0])
        chk(rd_last === VEC[i][32:1], $sformatf("R5 R7 vector %0d", i), rd_last, VEC[i][32:1]);
    end
    chk(rf[15] === 32'h1000 && rf[31] === 32'h2000, "R5 pc banks", rf[31], 32'h2000);

    // R7 R9: debug write latency and back-to-back stall
    bus(1, 0, 32'h0000_0107);
    @(negedge clk);
    stb = 1; we = 1; adr = 1; wd = 32'h0000_7777;
    @(posedge clk);
    @(negedge clk);
    we = 0;
    #1;
    chk(rf_we === 1 && rf_waddr === 5'd7 && rf_wdata === 32'h7777, "R7 writeback one cycle later", rf_wdata, 32'h7777);
    chk(stall === 1'b1, "R9 stall during writeback", {31'b0, stall}, 32'h1);
    @(negedge clk);
    chk(ack === 1'b0, "R1 no ack when stalled", {31'b0, ack}, 32'h0);
    #1;
    chk(stall === 1'b0, "R9 stall released", {31'b0, stall}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    stb = 0;
    chk(ack === 1 && rdata === 32'h7777, "R9 read new value", rdata, 32'h7777);

    // R5: out-of-range select
    bus(1, 0, 32'h0000_0128);
    bus(1, 1, 32'h0000_0099);
    chk(rf_we === 1'b0, "R5 high select write dropped", {31'b0, rf_we}, 32'h0);
    bus(0, 1, 0);
    chk(rd_last === 32'h0, "R5 high select reads zero", rd_last, 32'h0);
    bus(1, 0, 32'h0000_0108);
    bus(0, 1, 0);
    chk(rd_last === 32'hA000_0008, "R5 alias untouched", rd_last, 32'hA000_0008);

    // R4: reset and step pulses
    bus(1, 0, 32'h0000_0500);
    chk(cpu_rst === 1'b1, "R4 reset pulse", {31'b0, cpu_rst}, 32'h1);
    @(negedge clk);
    chk(cpu_rst === 1'b0, "R4 reset one cycle", {31'b0, cpu_rst}, 32'h0);
    bus(1, 0, 32'h0000_0900);
    chk(step === 1'b1, "R4 step pulse", {31'b0, step}, 32'h1);
    @(negedge clk);
    chk(step === 1'b0, "R4 step one cycle", {31'b0, step}, 32'h0);
    bus(0, 0, 0);
    chk(rd_last === 32'h0000_5300, "R4 pulse bits read zero", rd_last, 32'h5300);

    // R3: release
    bus(1, 0, 32'h0000_0000);
    repeat (5) @(negedge clk);
    bus(0, 0, 0);
    chk(rd_last === 32'h0000_5000, "R3 released", rd_last, 32'h5000);
    chk(irq_cnt == 1, "R10 no extra irq", irq_cnt, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule